// File: doc/BRIEF.md
# Cascadable Interval Timer

The block holds two 8-bit counter/compare halves, A and B, each with its own reference register and its own tick source. One mode bit selects how they work. Split, each half counts its own ticks and clears itself when it reaches its reference. Joined, the halves form one 16-bit interval timer. Half A holds the upper byte and half B holds the lower byte. The timer runs on half A's tick source and control bits.

Each half picks its tick from one of these sources:
- a private prescaler that divides the system clock by 512, 256, 64, 8 or 1;
- a slow sub-oscillator clock;
- an external clock pin.

A tick is counted only while the half's run state machine is in `ST_COUNT`. The machine moves from `ST_HALT` to `ST_COUNT` when the half is enabled with a source other than "stopped". It returns from `ST_COUNT` to `ST_HALT` when the enable drops or the source becomes "stopped". A match clears the counter, raises the half's sticky pending flag and drives its level interrupt output. Software clears the flag through a synchronous register port. The same port can also read the live counts.

Top module: `ivt_timer`

## Requirements
- R1: After reset, all six registers read 0 and both interrupt outputs are low. The register addresses are:
  - 0: control A
  - 1: control B
  - 2: reference A
  - 3: reference B
  - 4: count A (read only)
  - 5: count B (read only)
- R2: In each control register, bit 0 is the pending flag, bit 1 is the enable and bits 4:2 select the source. The source codes are:
  - 000: /512
  - 001: /256
  - 010: /64
  - 011: /8
  - 100: /1
  - 101: sub-oscillator
  - 110: external pin
  - 111: stopped

  With a /D prescaler source, the first tick after a counter clear comes D cycles after the clear, and later ticks follow every D cycles.
- R3: On a tick where the count equals the reference, the count returns to 0 instead of incrementing, so one period is (reference+1) ticks.
- R4: A match sets that half's pending flag, and the half's interrupt output follows the flag.
- R5: Writing 0 to a pending bit clears it, and writing 1 leaves it unchanged. If a match falls in the same cycle as a clearing write, the flag stays set.
- R6: Bit 7 of control A selects joined 16-bit mode when it is 1. In this mode the compare value is {reference A, reference B}, and a carry out of count B advances count A. Only half A's flag and interrupt are used, and half B's controls are ignored. Interrupt B stays low.
- R7: In split mode, the two halves count, match and flag independently of each other.
- R8: The external pin and the sub-oscillator clock each pass through a two-flop synchronizer. Each rising edge yields exactly one tick, however long the level is held.
- R9: With source code 111 or the enable at 0, the count holds its value.
- R10: Writing 1 to bit 5 of a control register zeroes that half's counter and prescaler. Bit 5 always reads 0. This clear takes priority over a match in the same cycle. Changing the mode bit zeroes both counters.
- R11: Reading a count returns its present value and does not affect counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| sub_clk | input | 1 | Asynchronous sub-oscillator clock |
| ext_clk | input | 1 | Asynchronous external clock pin |
| irq_a | output | 1 | Interrupt for half A (also the 16-bit timer) |
| irq_b | output | 1 | Interrupt for half B |

## Verification
A compare match and a software write to the same pending bit can land on the same clock edge. The bench provokes this with /1 ticks and reference 3, so matches fall every fourth cycle. It places a clearing write on exactly the edge of the second match and expects the interrupt to remain high. It then repeats the write one cycle later and expects the interrupt to drop. A counter clear is also timed against the 16-bit carry, and against a mode change that happens while the counter is running.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 3;

    typedef enum logic [2:0] {
        SRC_D512 = 3'b000,
        SRC_D256 = 3'b001,
        SRC_D64  = 3'b010,
        SRC_D8   = 3'b011,
        SRC_D1   = 3'b100,
        SRC_SUB  = 3'b101,
        SRC_EXT  = 3'b110,
        SRC_OFF  = 3'b111
    } src_t;

    typedef enum logic {
        ST_HALT  = 1'b0,
        ST_COUNT = 1'b1
    } run_st_t;

    localparam logic [ADDR_W-1:0] AD_CTLA = 3'd0;
    localparam logic [ADDR_W-1:0] AD_CTLB = 3'd1;
    localparam logic [ADDR_W-1:0] AD_REFA = 3'd2;
    localparam logic [ADDR_W-1:0] AD_REFB = 3'd3;
    localparam logic [ADDR_W-1:0] AD_CNTA = 3'd4;
    localparam logic [ADDR_W-1:0] AD_CNTB = 3'd5;

    localparam int unsigned B_PEND = 0;
    localparam int unsigned B_EN   = 1;
    localparam int unsigned B_SRCL = 2;
    localparam int unsigned B_SRCH = 4;
    localparam int unsigned B_CLR  = 5;
    localparam int unsigned B_JOIN = 7;
endpackage

// File: rtl/ivt_sync.sv
module ivt_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], async_in};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];

    // R8: a detected edge lasts exactly one cycle
    assert_single_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/ivt_tick.sv
module ivt_tick
    import ivt_pkg::*;
#(
    parameter int unsigned LOG_D512 = 9,
    parameter int unsigned LOG_D256 = 8,
    parameter int unsigned LOG_D64  = 6,
    parameter int unsigned LOG_D8   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  src_t src,
    input  logic sub_rise,
    input  logic ext_rise,
    output logic tick
);
    localparam int unsigned PW = LOG_D512;

    logic [PW-1:0] pcnt;

    always_ff @(posedge clk) begin
        if (!rst_n)       pcnt <= '0;
        else if (restart) pcnt <= '0;
        else              pcnt <= pcnt + 1'b1;
    end

    always_comb begin
        unique case (src)
            SRC_D512: tick = &pcnt[LOG_D512-1:0];
            SRC_D256: tick = &pcnt[LOG_D256-1:0];
            SRC_D64:  tick = &pcnt[LOG_D64-1:0];
            SRC_D8:   tick = &pcnt[LOG_D8-1:0];
            SRC_D1:   tick = 1'b1;
            SRC_SUB:  tick = sub_rise;
            SRC_EXT:  tick = ext_rise;
            SRC_OFF:  tick = 1'b0;
        endcase
    end

    // R2: a restart always starts a fresh prescaler phase
    assert_phase_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (pcnt == '0));
endmodule

// File: rtl/ivt_run.sv
module ivt_run
    import ivt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  src_t src,
    output logic run
);
    run_st_t st, st_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_HALT;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_HALT:  if (en && src != SRC_OFF) st_nx = ST_COUNT;
            ST_COUNT: if (!en || src == SRC_OFF) st_nx = ST_HALT;
        endcase
    end

    always_comb run = (st == ST_COUNT);

    // R9: a stopped source leaves the machine halted
    assert_halt_on_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_OFF || !en) |=> !run);
endmodule

// File: rtl/ivt_cnt.sv
module ivt_cnt #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         wipe,
    input  logic [W-1:0] ref_val,
    output logic [W-1:0] cnt,
    output logic         eq
);
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (wipe) cnt <= '0;
        else if (step) cnt <= cnt + 1'b1;
    end

    assign eq = (cnt == ref_val);

    // R9: without a step or a wipe the count holds
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !wipe) |=> $stable(cnt));
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
    import ivt_pkg::*;
#(
    parameter int unsigned CW          = DATA_W,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [CW-1:0]     reg_wdata,
    output logic [CW-1:0]     reg_rdata,
    input  logic              sub_clk,
    input  logic              ext_clk,
    output logic              irq_a,
    output logic              irq_b
);
    logic          joined;
    logic          en_a, en_b, pend_a, pend_b;
    src_t          src_a, src_b;
    logic [CW-1:0] ref_a, ref_b, cnt_a, cnt_b;

    logic wr_ctla, wr_ctlb, wr_refa, wr_refb;
    logic mode_flip, clr_a, clr_b;
    logic sub_rise, ext_rise, tick_a, tick_b, run_a, run_b;
    logic base_a, base_b, eq_a, eq_b, full_b;
    logic inc_a, inc_b, wipe_a, wipe_b, match_a, match_b;

    assign wr_ctla = reg_wr && (reg_addr == AD_CTLA);
    assign wr_ctlb = reg_wr && (reg_addr == AD_CTLB);
    assign wr_refa = reg_wr && (reg_addr == AD_REFA);
    assign wr_refb = reg_wr && (reg_addr == AD_REFB);

    assign mode_flip = wr_ctla && (reg_wdata[B_JOIN] != joined);
    assign clr_a = (wr_ctla && reg_wdata[B_CLR]) || mode_flip;
    assign clr_b = (wr_ctlb && reg_wdata[B_CLR] && !joined) || mode_flip
                 || (joined && wr_ctla && reg_wdata[B_CLR]);

    ivt_sync #(.STAGES(SYNC_STAGES)) u_sync_sub (
        .clk(clk), .rst_n(rst_n), .async_in(sub_clk), .rise(sub_rise));
    ivt_sync #(.STAGES(SYNC_STAGES)) u_sync_ext (
        .clk(clk), .rst_n(rst_n), .async_in(ext_clk), .rise(ext_rise));

    ivt_tick u_tick_a (
        .clk(clk), .rst_n(rst_n), .restart(clr_a), .src(src_a),
        .sub_rise(sub_rise), .ext_rise(ext_rise), .tick(tick_a));
    ivt_tick u_tick_b (
        .clk(clk), .rst_n(rst_n), .restart(clr_b), .src(src_b),
        .sub_rise(sub_rise), .ext_rise(ext_rise), .tick(tick_b));

    ivt_run u_run_a (.clk(clk), .rst_n(rst_n), .en(en_a), .src(src_a), .run(run_a));
    ivt_run u_run_b (.clk(clk), .rst_n(rst_n), .en(en_b), .src(src_b), .run(run_b));

    assign base_a = tick_a & run_a;
    assign base_b = tick_b & run_b;
    assign full_b = &cnt_b;

    always_comb begin
        if (joined) begin
            match_a = base_a && eq_a && eq_b && !clr_a;
            match_b = 1'b0;
            inc_b   = base_a;
            inc_a   = base_a && full_b;
            wipe_a  = clr_a || match_a;
            wipe_b  = clr_b || match_a;
        end else begin
            match_a = base_a && eq_a && !clr_a;
            match_b = base_b && eq_b && !clr_b;
            inc_a   = base_a;
            inc_b   = base_b;
            wipe_a  = clr_a || match_a;
            wipe_b  = clr_b || match_b;
        end
    end

    ivt_cnt #(.W(CW)) u_cnt_a (
        .clk(clk), .rst_n(rst_n), .step(inc_a), .wipe(wipe_a),
        .ref_val(ref_a), .cnt(cnt_a), .eq(eq_a));
    ivt_cnt #(.W(CW)) u_cnt_b (
        .clk(clk), .rst_n(rst_n), .step(inc_b), .wipe(wipe_b),
        .ref_val(ref_b), .cnt(cnt_b), .eq(eq_b));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            joined <= 1'b0;
            en_a   <= 1'b0;
            en_b   <= 1'b0;
            src_a  <= SRC_D512;
            src_b  <= SRC_D512;
            pend_a <= 1'b0;
            pend_b <= 1'b0;
            ref_a  <= '0;
            ref_b  <= '0;
        end else begin
            if (match_a)                           pend_a <= 1'b1;
            else if (wr_ctla && !reg_wdata[B_PEND]) pend_a <= 1'b0;
            if (match_b)                           pend_b <= 1'b1;
            else if (wr_ctlb && !reg_wdata[B_PEND]) pend_b <= 1'b0;
            if (wr_ctla) begin
                joined <= reg_wdata[B_JOIN];
                en_a   <= reg_wdata[B_EN];
                src_a  <= src_t'(reg_wdata[B_SRCH:B_SRCL]);
            end
            if (wr_ctlb) begin
                en_b  <= reg_wdata[B_EN];
                src_b <= src_t'(reg_wdata[B_SRCH:B_SRCL]);
            end
            if (wr_refa) ref_a <= reg_wdata;
            if (wr_refb) ref_b <= reg_wdata;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            AD_CTLA: begin
                reg_rdata[B_PEND]        = pend_a;
                reg_rdata[B_EN]          = en_a;
                reg_rdata[B_SRCH:B_SRCL] = src_a;
                reg_rdata[B_JOIN]        = joined;
            end
            AD_CTLB: begin
                reg_rdata[B_PEND]        = pend_b;
                reg_rdata[B_EN]          = en_b;
                reg_rdata[B_SRCH:B_SRCL] = src_b;
            end
            AD_REFA: reg_rdata = ref_a;
            AD_REFB: reg_rdata = ref_b;
            AD_CNTA: reg_rdata = cnt_a;
            AD_CNTB: reg_rdata = cnt_b;
            default: reg_rdata = '0;
        endcase
    end

    assign irq_a = pend_a;
    assign irq_b = pend_b;

    // R4: a match leaves the flag set
    assert_match_sets_pend_R4: assert property (@(posedge clk) disable iff (!rst_n)
        match_a |=> pend_a);
    // R5: only a write of 0 may clear the flag
    assert_pend_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_a && !(wr_ctla && !reg_wdata[B_PEND])) |=> pend_a);
    // R6: half B never raises its flag while joined
    assert_joined_b_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (joined && !pend_b) |=> !pend_b);
    // R10: a clear write leaves count A at zero
    assert_clear_zeroes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctla && reg_wdata[B_CLR]) |=> (cnt_a == '0));
endmodule

// File: tb/sim_ivt_timer.sv
`timescale 1ns/1ps
module sim_ivt_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sub_clk = 1'b0;
    logic       ext_clk = 1'b0;
    logic       irq_a, irq_b;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ivt_timer u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sub_clk(sub_clk),
        .ext_clk(ext_clk), .irq_a(irq_a), .irq_b(irq_b));

    task automatic chk(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    function automatic logic [7:0] cb(bit j, bit clr, logic [2:0] s, bit en, bit p);
        return {j, 1'b0, clr, s, en, p};
    endfunction

    task automatic t_reset;
        int v;
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk("R1 reset register", v, 0);
        end
        chk("R1 reset irq_a", int'(irq_a), 0);
        chk("R1 reset irq_b", int'(irq_b), 0);
    endtask

    task automatic t_basic_match;
        int v;
        wr(3'd2, 8'd5);
        wr(3'd0, cb(0, 0, 3'b100, 1, 1));
        cyc(2);
        wr(3'd0, cb(0, 1, 3'b100, 1, 0));
        cyc(5);
        rd(3'd4, v); chk("R3 count reaches ref", v, 5);
        chk("R4 no flag before match", int'(irq_a), 0);
        cyc(1);
        rd(3'd4, v); chk("R3 count wraps to 0", v, 0);
        chk("R4 irq_a raised", int'(irq_a), 1);
        rd(3'd0, v); chk("R4 pending bit 0 set", v & 1, 1);
        rd(3'd5, v); chk("R7 idle half B untouched", v, 0);
        chk("R7 irq_b low", int'(irq_b), 0);
    endtask

    task automatic t_div8_b;
        int v;
        wr(3'd3, 8'd2);
        wr(3'd1, cb(0, 0, 3'b011, 1, 1));
        cyc(2);
        wr(3'd1, cb(0, 1, 3'b011, 1, 0));
        cyc(7);
        rd(3'd5, v); chk("R2 /8 no tick before 8 cycles", v, 0);
        cyc(1);
        rd(3'd5, v); chk("R2 /8 first tick", v, 1);
        cyc(15);
        rd(3'd5, v); chk("R3 /8 count at ref", v, 2);
        chk("R7 irq_b not yet", int'(irq_b), 0);
        cyc(1);
        rd(3'd5, v); chk("R3 /8 wrap", v, 0);
        chk("R7 irq_b raised", int'(irq_b), 1);
    endtask

    task automatic t_ratios;
        int v;
        wr(3'd3, 8'hFF);
        wr(3'd1, cb(0, 1, 3'b010, 1, 0));
        cyc(640);
        rd(3'd5, v); chk("R2 /64 ratio", v, 10);
        wr(3'd1, cb(0, 1, 3'b001, 1, 0));
        cyc(1024);
        rd(3'd5, v); chk("R2 /256 ratio", v, 4);
        wr(3'd1, cb(0, 1, 3'b000, 1, 0));
        cyc(1535);
        rd(3'd5, v); chk("R2 /512 before third tick", v, 2);
        cyc(1);
        rd(3'd5, v); chk("R2 /512 third tick", v, 3);
    endtask

    task automatic t_pending;
        wr(3'd2, 8'd3);
        wr(3'd0, cb(0, 1, 3'b100, 1, 0));
        cyc(4);
        chk("R4 match sets irq_a", int'(irq_a), 1);
        wr(3'd0, cb(0, 0, 3'b100, 1, 1));
        chk("R5 write 1 keeps flag", int'(irq_a), 1);
        cyc(2);
        wr(3'd0, cb(0, 0, 3'b100, 1, 0));
        chk("R5 match beats clear", int'(irq_a), 1);
        wr(3'd0, cb(0, 0, 3'b100, 1, 0));
        chk("R5 write 0 clears flag", int'(irq_a), 0);
    endtask

    task automatic t_joined;
        int v, w;
        wr(3'd2, 8'h01);
        wr(3'd3, 8'h10);
        wr(3'd0, cb(1, 0, 3'b100, 1, 0));
        cyc(2);
        wr(3'd1, cb(0, 1, 3'b100, 1, 0));
        wr(3'd0, cb(1, 1, 3'b100, 1, 0));
        cyc(256);
        rd(3'd4, v); rd(3'd5, w);
        chk("R6 carry into upper byte", (v << 8) | w, 16'h0100);
        cyc(16);
        rd(3'd4, v); rd(3'd5, w);
        chk("R6 16-bit count at ref", (v << 8) | w, 16'h0110);
        chk("R6 no flag before match", int'(irq_a), 0);
        cyc(1);
        rd(3'd4, v); rd(3'd5, w);
        chk("R6 16-bit wrap", (v << 8) | w, 0);
        chk("R6 irq_a on 16-bit match", int'(irq_a), 1);
        chk("R6 irq_b stays low", int'(irq_b), 0);
        rd(3'd0, v); chk("R6 mode bit reads 1", (v >> 7) & 1, 1);
        cyc(50);
        wr(3'd0, cb(0, 0, 3'b100, 1, 1));
        rd(3'd4, v); chk("R10 mode change zeroes A", v, 0);
        rd(3'd5, v); chk("R10 mode change zeroes B", v, 0);
        wr(3'd0, cb(0, 1, 3'b100, 1, 1));
        rd(3'd0, v); chk("R10 clear bit reads 0", (v >> 5) & 1, 0);
        wr(3'd1, cb(0, 0, 3'b111, 0, 0));
    endtask

    task automatic t_async_sources;
        int v;
        wr(3'd2, 8'hFF);
        wr(3'd3, 8'hFF);
        wr(3'd0, cb(0, 1, 3'b110, 1, 0));
        wr(3'd1, cb(0, 1, 3'b101, 1, 0));
        cyc(2);
        wr(3'd0, cb(0, 1, 3'b110, 1, 0));
        wr(3'd1, cb(0, 1, 3'b101, 1, 0));
        ext_clk = 1'b1; cyc(20); ext_clk = 1'b0; cyc(3);
        for (int i = 0; i < 4; i++) begin
            ext_clk = 1'b1; cyc(3); ext_clk = 1'b0; cyc(3);
        end
        for (int i = 0; i < 3; i++) begin
            sub_clk = 1'b1; cyc(4); sub_clk = 1'b0; cyc(4);
        end
        cyc(4);
        rd(3'd4, v); chk("R8 one tick per external edge", v, 5);
        rd(3'd5, v); chk("R8 one tick per sub edge", v, 3);
    endtask

    task automatic t_stop_and_read;
        int v1, v2;
        wr(3'd0, cb(0, 0, 3'b100, 1, 0));
        cyc(2);
        wr(3'd0, cb(0, 1, 3'b100, 1, 0));
        for (int k = 1; k <= 10; k++) begin
            cyc(1);
            rd(3'd4, v1);
            chk("R11 live count readback", v1, k);
        end
        wr(3'd0, cb(0, 0, 3'b111, 1, 0));
        cyc(2);
        rd(3'd4, v1); cyc(10); rd(3'd4, v2);
        chk("R9 source 111 holds count", v2, v1);
        wr(3'd0, cb(0, 0, 3'b100, 0, 0));
        cyc(2);
        rd(3'd4, v1); cyc(10); rd(3'd4, v2);
        chk("R9 enable 0 holds count", v2, v1);
    endtask

    initial begin
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_basic_match();
        t_div8_b();
        t_ratios();
        t_pending();
        t_joined();
        t_async_sources();
        t_stop_and_read();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule